// File: doc/BRIEF.md
# Three-Level DMA Address Translator

This block turns a device DMA address into a host physical page address. It walks a three-level table in memory: a region table, then a segment table, then a page table. Each request carries the address and four state bits of the issuing function. With the request come a raw table origin, which still has flag bits in its low part, and an inclusive address window given as a base and a limit. Table entries are fetched as 64-bit words through a simple read request/response port. The block handles one walk at a time and holds its request-ready signal low while a walk is in progress.

Before any memory read, the request is classified in a fixed order:

1. A function that is not fully set up gets a "no access" answer.
2. The fixed interrupt-message address bypasses translation and is routed to interrupt-notify space.
3. A zero origin is rejected.
4. An address outside the window is rejected.

Every other request starts the table walk. Every kind of failure returns an error response and emits an error event with its own code in the same cycle. Failures also set two sticky function flags, error-state and store-blocked, which only reset clears.

Top module: `dma_xlat_top`

## Requirements
- R1: Unless fn_configured, fn_present, fn_enabled and fn_xlat_on are all 1, the response has rsp_perm=0, rsp_addr=0, rsp_mask all ones, rsp_error=0, no event and no memory read.
- R2: A request whose address equals MSI_ADDR (default 0x0C000000) is answered without any read, even when the origin is zero. The answer has rsp_to_msi=1, rsp_addr equal to the request address, rsp_mask=0xFFF and rsp_perm=1.
- R3: The origin is tbl_origin with bits [11:0] cleared. If that value is zero, the request fails with event code 0x28 and qualifier 0, and no read is made.
- R4: An address below win_base or above win_limit fails with event code 0x22 and qualifier 0, and no read is made. Both window bounds are inclusive.
- R5: The page index is address bits [19:12], the segment index bits [30:20] and the region index bits [41:31]. The entry read at each level is at the table base plus the index times 8.
- R6: The region entry is used only if its bits [3:2] equal 2'b11. The segment-table base is then the entry with bits [11:0] cleared. Any other type ends the walk after one read.
- R7: The segment entry is used only if its bits [3:2] equal 2'b10. The page-table base is then the entry with bits [11:0] cleared. Any other type ends the walk after two reads.
- R8: An all-zero page entry is a walk failure. Any other page entry gives rsp_addr equal to the entry with bits [11:0] cleared, rsp_mask=0xFFF and rsp_perm equal to the inverse of entry bit 10.
- R9: A walk failure has event code 0x02 and qualifier 1. On every failure, rsp_error=1, rsp_perm=0, rsp_addr=0 and rsp_mask is all ones. evt_valid rises in the same cycle as the response, with evt_addr equal to the request address. err_state and store_blocked become 1 and stay 1 until reset.
- R10: req_ready is low from the cycle after acceptance until the cycle after the response. Each table read is issued only after the previous response arrives. A read request holds its address until mem_rd_ready is 1.
- R11: rsp_valid is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translate request |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | ADDR_W | Device DMA address |
| fn_configured | input | 1 | Function configured |
| fn_present | input | 1 | Device present |
| fn_enabled | input | 1 | Handle enabled |
| fn_xlat_on | input | 1 | Translation turned on |
| tbl_origin | input | ADDR_W | Raw region-table origin with flag bits |
| win_base | input | ADDR_W | Lowest allowed address |
| win_limit | input | ADDR_W | Highest allowed address |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts read |
| mem_rd_addr | output | ADDR_W | Table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | ADDR_W | Table entry |
| rsp_valid | output | 1 | Translation result valid |
| rsp_addr | output | ADDR_W | Translated page address |
| rsp_mask | output | ADDR_W | Page offset mask |
| rsp_perm | output | 1 | 1 = access allowed |
| rsp_to_msi | output | 1 | Routed to interrupt-notify space |
| rsp_error | output | 1 | Translation failed |
| evt_valid | output | 1 | Error event |
| evt_code | output | 8 | Error event code |
| evt_qual | output | 1 | Error qualifier bit |
| evt_addr | output | ADDR_W | Faulting address |
| err_state | output | 1 | Sticky error-state flag |
| store_blocked | output | 1 | Sticky store-blocked flag |

## Verification
If the sequencer enters the wrong state, the read count, the read addresses or the response timing change on the very next transaction. The bench therefore records every table read and compares it with addresses computed from the index split. A wrong entry-type decode or a wrong base extraction shows up one read later, as a wrong address or as a missing error event. A wrong priority in the precheck shows as a wrong event code, or as reads that should not have happened, within a few cycles of acceptance. A sticky flag that clears by itself is caught at the next response.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REGION, ST_RD_SEGMENT, ST_RD_PAGE, ST_DONE, ST_ERR
  } walk_state_t;

  typedef enum logic [2:0] {
    PK_GATED, PK_MSI, PK_NOAS, PK_RANGE, PK_WALK
  } pre_kind_t;

  typedef enum logic [1:0] {
    LV_REGION, LV_SEGMENT, LV_PAGE
  } level_t;

  localparam logic [7:0] EC_NO_SPACE = 8'h28;
  localparam logic [7:0] EC_RANGE    = 8'h22;
  localparam logic [7:0] EC_WALK     = 8'h02;

  localparam logic [1:0] TY_REGION  = 2'b11;
  localparam logic [1:0] TY_SEGMENT = 2'b10;
  localparam int         TY_LSB     = 2;
  localparam int         INV_BIT    = 10;
endpackage

// File: rtl/xlat_precheck.sv
module xlat_precheck
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int FLAG_BITS = 12,
  parameter logic [ADDR_W-1:0] MSI_ADDR = ADDR_W'(64'h0000_0000_0C00_0000)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              fn_configured,
  input  logic              fn_present,
  input  logic              fn_enabled,
  input  logic              fn_xlat_on,
  input  logic [ADDR_W-1:0] origin_raw,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output pre_kind_t         kind,
  output logic [ADDR_W-1:0] origin_clean
);
  logic fn_ready;

  assign fn_ready     = fn_configured & fn_present & fn_enabled & fn_xlat_on;
  assign origin_clean = {origin_raw[ADDR_W-1:FLAG_BITS], {FLAG_BITS{1'b0}}};

  always_comb begin
    if (!fn_ready)                          kind = PK_GATED;
    else if (addr == MSI_ADDR)              kind = PK_MSI;
    else if (origin_clean == '0)            kind = PK_NOAS;
    else if ((addr < base) || (addr > limit)) kind = PK_RANGE;
    else                                    kind = PK_WALK;
  end
endmodule

// File: rtl/xlat_entry_decode.sv
module xlat_entry_decode
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PG_SHIFT = 12
) (
  input  level_t            level,
  input  logic [ADDR_W-1:0] entry,
  output logic              ok,
  output logic [ADDR_W-1:0] next_base,
  output logic              inv
);
  logic [1:0] ety;

  assign ety       = entry[TY_LSB +: 2];
  assign next_base = {entry[ADDR_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  assign inv       = entry[INV_BIT];

  always_comb begin
    case (level)
      LV_REGION:  ok = (ety == TY_REGION);
      LV_SEGMENT: ok = (ety == TY_SEGMENT);
      LV_PAGE:    ok = (entry != '0);
      default:    ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlat_walk_fsm.sv
module xlat_walk_fsm
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PG_SHIFT = 12,
  parameter int PX_BITS = 8,
  parameter int SX_BITS = 11,
  parameter int RX_BITS = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  pre_kind_t         kind,
  input  logic [ADDR_W-1:0] origin_clean,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_mask,
  output logic              rsp_perm,
  output logic              rsp_to_msi,
  output logic              rsp_error,
  output logic              evt_valid,
  output logic [7:0]        evt_code,
  output logic              evt_qual,
  output logic [ADDR_W-1:0] evt_addr
);
  localparam int PX_LSB = PG_SHIFT;
  localparam int SX_LSB = PX_LSB + PX_BITS;
  localparam int RX_LSB = SX_LSB + SX_BITS;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PG_SHIFT) - 64'd1);

  walk_state_t       state;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_pend;
  level_t            level;
  logic              dec_ok;
  logic [ADDR_W-1:0] dec_base;
  logic              dec_inv;

  function automatic logic [ADDR_W-1:0] slot(input logic [ADDR_W-1:0] b,
                                             input logic [ADDR_W-1:0] idx);
    return b + (idx << 3);
  endfunction

  always_comb begin
    case (state)
      ST_RD_SEGMENT: level = LV_SEGMENT;
      ST_RD_PAGE:    level = LV_PAGE;
      default:       level = LV_REGION;
    endcase
  end

  xlat_entry_decode #(.ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT)) u_dec (
    .level     (level),
    .entry     (mem_rsp_data),
    .ok        (dec_ok),
    .next_base (dec_base),
    .inv       (dec_inv)
  );

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = rd_pend;
  assign rsp_valid    = (state == ST_DONE) || (state == ST_ERR);
  assign rsp_error    = (state == ST_ERR);
  assign evt_valid    = (state == ST_ERR);
  assign evt_addr     = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      addr_q      <= '0;
      rd_pend     <= 1'b0;
      mem_rd_addr <= '0;
      rsp_addr    <= '0;
      rsp_mask    <= '0;
      rsp_perm    <= 1'b0;
      rsp_to_msi  <= 1'b0;
      evt_code    <= '0;
      evt_qual    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q     <= req_addr;
            rsp_addr   <= '0;
            rsp_mask   <= '1;
            rsp_perm   <= 1'b0;
            rsp_to_msi <= 1'b0;
            evt_qual   <= 1'b0;
            case (kind)
              PK_GATED: state <= ST_DONE;
              PK_MSI: begin
                rsp_addr   <= req_addr;
                rsp_mask   <= PAGE_MASK;
                rsp_perm   <= 1'b1;
                rsp_to_msi <= 1'b1;
                state      <= ST_DONE;
              end
              PK_NOAS: begin
                evt_code <= EC_NO_SPACE;
                state    <= ST_ERR;
              end
              PK_RANGE: begin
                evt_code <= EC_RANGE;
                state    <= ST_ERR;
              end
              default: begin
                mem_rd_addr <= slot(origin_clean, ADDR_W'(req_addr[RX_LSB +: RX_BITS]));
                rd_pend     <= 1'b1;
                state       <= ST_RD_REGION;
              end
            endcase
          end
        end
        ST_RD_REGION, ST_RD_SEGMENT, ST_RD_PAGE: begin
          if (rd_pend) begin
            if (mem_rd_ready) rd_pend <= 1'b0;
          end else if (mem_rsp_valid) begin
            if (!dec_ok) begin
              evt_code <= EC_WALK;
              evt_qual <= 1'b1;
              state    <= ST_ERR;
            end else if (state == ST_RD_REGION) begin
              mem_rd_addr <= slot(dec_base, ADDR_W'(addr_q[SX_LSB +: SX_BITS]));
              rd_pend     <= 1'b1;
              state       <= ST_RD_SEGMENT;
            end else if (state == ST_RD_SEGMENT) begin
              mem_rd_addr <= slot(dec_base, ADDR_W'(addr_q[PX_LSB +: PX_BITS]));
              rd_pend     <= 1'b1;
              state       <= ST_RD_PAGE;
            end else begin
              rsp_addr <= dec_base;
              rsp_mask <= PAGE_MASK;
              rsp_perm <= ~dec_inv;
              state    <= ST_DONE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R10
  busy_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R2
  msi_route_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_to_msi) |-> (rsp_addr == addr_q && !rsp_error));
endmodule

// File: rtl/dma_xlat_top.sv
module dma_xlat_top
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int PG_SHIFT = 12,
  parameter int PX_BITS = 8,
  parameter int SX_BITS = 11,
  parameter int RX_BITS = 11,
  parameter logic [ADDR_W-1:0] MSI_ADDR = ADDR_W'(64'h0000_0000_0C00_0000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              fn_configured,
  input  logic              fn_present,
  input  logic              fn_enabled,
  input  logic              fn_xlat_on,
  input  logic [ADDR_W-1:0] tbl_origin,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_limit,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [ADDR_W-1:0] rsp_mask,
  output logic              rsp_perm,
  output logic              rsp_to_msi,
  output logic              rsp_error,
  output logic              evt_valid,
  output logic [7:0]        evt_code,
  output logic              evt_qual,
  output logic [ADDR_W-1:0] evt_addr,
  output logic              err_state,
  output logic              store_blocked
);
  pre_kind_t         kind;
  logic [ADDR_W-1:0] origin_clean;

  xlat_precheck #(.ADDR_W(ADDR_W), .FLAG_BITS(PG_SHIFT), .MSI_ADDR(MSI_ADDR)) u_pre (
    .addr          (req_addr),
    .fn_configured (fn_configured),
    .fn_present    (fn_present),
    .fn_enabled    (fn_enabled),
    .fn_xlat_on    (fn_xlat_on),
    .origin_raw    (tbl_origin),
    .base          (win_base),
    .limit         (win_limit),
    .kind          (kind),
    .origin_clean  (origin_clean)
  );

  xlat_walk_fsm #(
    .ADDR_W(ADDR_W), .PG_SHIFT(PG_SHIFT), .PX_BITS(PX_BITS),
    .SX_BITS(SX_BITS), .RX_BITS(RX_BITS)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .kind          (kind),
    .origin_clean  (origin_clean),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr),
    .rsp_mask      (rsp_mask),
    .rsp_perm      (rsp_perm),
    .rsp_to_msi    (rsp_to_msi),
    .rsp_error     (rsp_error),
    .evt_valid     (evt_valid),
    .evt_code      (evt_code),
    .evt_qual      (evt_qual),
    .evt_addr      (evt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_state     <= 1'b0;
      store_blocked <= 1'b0;
    end else if (evt_valid) begin
      err_state     <= 1'b1;
      store_blocked <= 1'b1;
    end
  end

  // R9
  evt_flags_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> (err_state && store_blocked));

  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_state || store_blocked) |=> (err_state && store_blocked));

  // R9
  evt_perm_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> (rsp_valid && !rsp_perm));
endmodule

// File: tb/sim_dma_xlat_top.sv
module sim_dma_xlat_top;
  localparam logic [63:0] MSI  = 64'h0000_0000_0C00_0000;
  localparam logic [63:0] BASE = 64'h0000_0000_0010_0000;
  localparam logic [63:0] LIM  = 64'h0000_03FF_FFFF_FFFF;
  localparam logic [63:0] ORG  = 64'h0000_0000_0001_0ABC;
  localparam logic [63:0] RT   = 64'h0000_0000_0001_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [63:0] req_addr = '0;
  logic fn_configured = 1'b0, fn_present = 1'b0, fn_enabled = 1'b0, fn_xlat_on = 1'b0;
  logic [63:0] tbl_origin = '0;
  logic [63:0] win_base = BASE;
  logic [63:0] win_limit = LIM;
  logic mem_rd_valid;
  logic mem_rd_ready = 1'b0;
  logic [63:0] mem_rd_addr;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic rsp_valid, rsp_perm, rsp_to_msi, rsp_error, evt_valid, evt_qual;
  logic [63:0] rsp_addr, rsp_mask, evt_addr;
  logic [7:0] evt_code;
  logic err_state, store_blocked;

  int checks = 0;
  int errors = 0;
  int reads = 0;
  int cyc = 0;
  int pend_lat = 0;
  logic [63:0] pend_addr = '0;
  logic [63:0] rd_seen [3];
  bit sticky = 1'b0;

  always #4 clk = ~clk;

  dma_xlat_top #(.MSI_ADDR(MSI)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .fn_configured(fn_configured), .fn_present(fn_present),
    .fn_enabled(fn_enabled), .fn_xlat_on(fn_xlat_on), .tbl_origin(tbl_origin),
    .win_base(win_base), .win_limit(win_limit), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_mask(rsp_mask),
    .rsp_perm(rsp_perm), .rsp_to_msi(rsp_to_msi), .rsp_error(rsp_error),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_qual(evt_qual),
    .evt_addr(evt_addr), .err_state(err_state), .store_blocked(store_blocked)
  );

  function automatic logic [63:0] page_pa(input logic [63:0] r, input logic [63:0] s,
                                          input logic [63:0] p);
    return 64'h1000_0000_0000 | (r << 32) | (s << 20) | (p << 12);
  endfunction

  // Table contents computed from the address
  function automatic logic [63:0] mem_word(input logic [63:0] a);
    logic [63:0] r, s, p, off;
    if (a >= RT && a < RT + 64'd16384) begin
      r = (a - RT) >> 3;
      if (r == 64'd5) return (64'h4000_0000 + (r << 16)) | 64'h8;
      return (64'h4000_0000 + (r << 16)) | 64'hC | 64'h300;
    end else if (a >= 64'h4000_0000 && a < 64'h4800_0000) begin
      r = (a - 64'h4000_0000) >> 16;
      s = (a & 64'hFFFF) >> 3;
      if (s == 64'd7) return 64'h8000_0000 | 64'hC;
      return (64'h8000_0000 + (r << 24) + (s << 12)) | 64'h8 | 64'h40;
    end else if (a >= 64'h8000_0000 && a < 64'h10_0000_0000) begin
      off = a - 64'h8000_0000;
      r = off >> 24;
      s = (off >> 12) & 64'hFFF;
      p = (off & 64'hFFF) >> 3;
      if (p == 64'd255) return '0;
      return page_pa(r, s, p) | 64'h5 | ((p == 64'd3) ? 64'h400 : 64'h0);
    end
    return '0;
  endfunction

  // Memory responder: varying ready and latency
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend_lat > 0) begin
        pend_lat--;
        if (pend_lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_word(pend_addr);
        end
      end
      mem_rd_ready = (cyc % 3 != 1);
      if (mem_rd_valid && mem_rd_ready) begin
        pend_addr = mem_rd_addr;
        pend_lat  = 1 + (cyc % 3);
        if (reads < 3) rd_seen[reads] = mem_rd_addr;
        reads++;
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sticky = 1'b0;
    @(negedge clk);
    chk("reset req_ready", {63'd0, req_ready}, 64'd1);
    chk("reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("reset mem_rd_valid", {63'd0, mem_rd_valid}, 64'd0);
    chk("R9 reset flags", {62'd0, err_state, store_blocked}, 64'd0);
  endtask

  task automatic do_req(input logic [63:0] a, input logic [3:0] fn, input logic [63:0] org);
    int kind; int ereads; bit eerr; bit eperm; bit emsi;
    logic [63:0] eaddr, emask, ecode, rx, sx, px;
    logic [63:0] era [3];
    int n;
    rx = (a >> 31) & 64'h7FF;
    sx = (a >> 20) & 64'h7FF;
    px = (a >> 12) & 64'hFF;
    era[0] = (org & ~64'hFFF) + (rx << 3);
    era[1] = 64'h4000_0000 + (rx << 16) + (sx << 3);
    era[2] = 64'h8000_0000 + (rx << 24) + (sx << 12) + (px << 3);
    ereads = 0; eerr = 0; eperm = 0; emsi = 0; eaddr = '0; emask = '1; ecode = '0;
    if (fn != 4'hF) kind = 0;
    else if (a == MSI) kind = 1;
    else if ((org >> 12) == 64'd0) kind = 2;
    else if (a < BASE || a > LIM) kind = 3;
    else kind = 4;
    case (kind)
      1: begin emsi = 1; eaddr = a; emask = 64'hFFF; eperm = 1; end
      2: begin eerr = 1; ecode = 64'h28; end
      3: begin eerr = 1; ecode = 64'h22; end
      4: begin
        if (rx == 64'd5) begin eerr = 1; ecode = 64'h02; ereads = 1; end
        else if (sx == 64'd7) begin eerr = 1; ecode = 64'h02; ereads = 2; end
        else if (px == 64'd255) begin eerr = 1; ecode = 64'h02; ereads = 3; end
        else begin
          ereads = 3; eaddr = page_pa(rx, sx, px); emask = 64'hFFF;
          eperm = (px != 64'd3);
        end
      end
      default: ;
    endcase
    reads = 0;
    req_addr = a; tbl_origin = org;
    {fn_configured, fn_present, fn_enabled, fn_xlat_on} = fn;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy after accept", {63'd0, req_ready}, 64'd0);
    n = 0;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
      if (!rsp_valid) chk("R10 busy during walk", {63'd0, req_ready}, 64'd0);
    end
    chk("R10 response arrives", {63'd0, rsp_valid}, 64'd1);
    if (kind == 0) begin
      chk("R1 gated addr", rsp_addr, 64'd0);
      chk("R1 gated perm/err", {62'd0, rsp_perm, rsp_error}, 64'd0);
      chk("R1 gated mask", rsp_mask, '1);
    end else if (kind == 1) begin
      chk("R2 bypass addr", rsp_addr, eaddr);
      chk("R2 bypass route", {62'd0, rsp_to_msi, rsp_perm}, 64'd3);
      chk("R2 bypass mask", rsp_mask, 64'hFFF);
    end else if (eerr) begin
      chk("R9 error resp", {61'd0, rsp_error, rsp_perm, rsp_to_msi}, 64'd4);
      chk("R9 error addr/mask", rsp_addr | ~rsp_mask, 64'd0);
      chk("R9 event valid", {63'd0, evt_valid}, 64'd1);
      chk("R3 R4 R9 event code", {56'd0, evt_code}, ecode);
      chk("R9 event qualifier", {63'd0, evt_qual}, (ecode == 64'h02) ? 64'd1 : 64'd0);
      chk("R9 event addr", evt_addr, a);
    end else begin
      chk("R8 page addr", rsp_addr, eaddr);
      chk("R8 page mask", rsp_mask, emask);
      chk("R8 perm", {63'd0, rsp_perm}, {63'd0, eperm});
      chk("R8 no error", {62'd0, rsp_error, rsp_to_msi}, 64'd0);
    end
    if (!eerr) chk("R9 no event", {63'd0, evt_valid}, 64'd0);
    chk("R5 read count", 64'(reads), 64'(ereads));
    for (int i = 0; i < 3; i++)
      if (i < ereads && i < reads)
        chk($sformatf("R5 R6 R7 read %0d addr", i), rd_seen[i], era[i]);
    @(negedge clk);
    if (eerr) sticky = 1'b1;
    chk("R11 single pulse", {63'd0, rsp_valid}, 64'd0);
    chk("R10 ready after response", {63'd0, req_ready}, 64'd1);
    chk("R9 sticky flags", {62'd0, err_state, store_blocked}, sticky ? 64'd3 : 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: every gating combination
    for (int f = 0; f < 16; f++)
      do_req(64'h0000_0000_0310_2000, 4'(f), ORG);
    // R2: bypass with normal and zero origin
    do_req(MSI, 4'hF, ORG);
    do_req(MSI, 4'hF, 64'h0);
    // R3: zero origin, and origin with only flag bits set
    do_req(64'h0000_0000_0310_2000, 4'hF, 64'h0);
    do_reset();
    do_req(64'h0000_0000_0310_2000, 4'hF, 64'h0000_0000_0000_0ABC);
    // R4: window boundaries, inclusive
    do_reset();
    do_req(BASE, 4'hF, ORG);
    do_req(BASE - 64'd1, 4'hF, ORG);
    do_reset();
    do_req(LIM + 64'd1, 4'hF, ORG);
    do_req(LIM, 4'hF, ORG);
    // R5 R6 R7 R8: sweep of indices
    do_reset();
    for (int r = 0; r < 6; r++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++) begin
          logic [63:0] rv, sv, pv, av;
          rv = (r == 0) ? 64'd0 : (r == 1) ? 64'd1 : (r == 2) ? 64'd2 :
               (r == 3) ? 64'd5 : (r == 4) ? 64'd100 : 64'd2047;
          sv = (s == 0) ? 64'd1 : (s == 1) ? 64'd6 : (s == 2) ? 64'd7 : 64'd2047;
          pv = (p == 0) ? 64'd0 : (p == 1) ? 64'd3 : (p == 2) ? 64'd255 : 64'd17;
          av = (rv << 31) | (sv << 20) | (pv << 12) | ((rv * 7 + sv) & 64'hFFF);
          do_req(av, 4'hF, ORG);
        end
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule